// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block tracks the status and error state of a single DMA channel. When software starts a transfer, the block checks the programmed setup. It tests the byte count, the source address and the destination address against the requested source and destination transfer sizes. A setup that passes makes the channel busy. A setup that fails raises a configuration-error flag, and the channel stays idle. While the channel is busy, the block follows three things from its surroundings: arbiter grants, bus-error reports from the read and write phases, and beat completions with the count still remaining. From these it maintains the request, busy and done indications.

Software reads a status byte and writes it back to clear it. Writing a one to the done position wipes every flag and stops an active transfer. An interrupt line is raised while any terminal flag is set and interrupts are enabled. An 8-bit vector register is driven onto the data bus during an interrupt-acknowledge cycle. The block does not move data, arbitrate the bus or step the addresses; those are external and appear here only as inputs.

Top module: `dma_stat_tracker`

## Requirements
- R1: After reset the status byte reads 0x00 and the vector register reads 0x0F. The status byte layout is: bit 6 configuration error, bit 5 read-phase bus error, bit 4 write-phase bus error, bit 2 request, bit 1 busy, bit 0 done. Bits 7 and 3 always read 0.
- R2: A start on an idle channel sets bit 6 when the byte count is not a whole multiple of the source size or of the destination size. Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 = 16 bytes.
- R3: A start on an idle channel also sets bit 6 when either address is not aligned to its own size. With a configuration error the channel never becomes busy. A start with a clean setup sets busy (bit 1).
- R4: The request bit reads 1 exactly while the channel is busy and the grant input is low. It reads 0 in any cycle in which grant is high.
- R5: A read-phase bus error on a busy channel sets bit 5 and clears busy. A write-phase bus error sets bit 4 and clears busy. Both errors in the same cycle set both bits. Bus errors on an idle channel have no effect.
- R6: A beat completion on a busy channel, with a remaining byte count of zero and no bus error, sets done and clears busy. A beat completion with a nonzero remaining count changes nothing.
- R7: Writing the status byte (select 0) with bit 0 = 1 clears every flag and aborts an active transfer; this wins over any event in the same cycle. Writing with bit 0 = 0 has no effect.
- R8: The interrupt output equals the interrupt enable ANDed with the OR of done and the three error flags.
- R9: Writes with select 1 load the vector register. While the acknowledge strobe is high, the bus output carries the vector; otherwise the bus output is 0x00.
- R10: A start while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle transfer start request |
| byteCount | input | CNT_W | Programmed byte count checked at start |
| srcAddr | input | ADDR_W | Programmed source address |
| dstAddr | input | ADDR_W | Programmed destination address |
| srcSize | input | 2 | Source transfer size code |
| dstSize | input | 2 | Destination transfer size code |
| grant | input | 1 | Channel currently selected by the arbiter |
| rdBusErr | input | 1 | Bus error reported in a read phase |
| wrBusErr | input | 1 | Bus error reported in a write phase |
| beatDone | input | 1 | A transfer beat completed |
| bytesLeft | input | CNT_W | Remaining byte count after the completed beat |
| intEnable | input | 1 | Interrupt enable |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 status, 1 vector |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register |
| iackStrobe | input | 1 | Interrupt-acknowledge strobe for this channel |
| busData | output | 8 | Vector driven during acknowledge, else zero |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit address and a 6-bit count. At these widths every size pair can be swept against every count up to 31 and against every source and destination offset within a 16-byte line. This covers every alignment case and every divisibility case of the setup check, and each vector's expected flag is computed by modular arithmetic. Directed sequences then step through grant, both bus-error phases, completion, write-one abort, write-zero, the acknowledge path and starts while busy.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

  localparam int DoneBit   = 0;
  localparam int BusyBit   = 1;
  localparam int ReqBit    = 2;
  localparam int DstErrBit = 4;
  localparam int SrcErrBit = 5;
  localparam int CfgErrBit = 6;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'b00,
    SZ_BYTE  = 2'b01,
    SZ_HALF  = 2'b10,
    SZ_LINE  = 2'b11
  } xferSize_e;

  typedef struct packed {
    logic clrAll;
    logic setCfgErr;
    logic setSrcErr;
    logic setDstErr;
    logic setBusy;
    logic clrBusy;
    logic setDone;
    logic wrVector;
  } statStrobe_t;

  function automatic logic [3:0] sizeMask(input logic [1:0] code);
    case (xferSize_e'(code))
      SZ_WORD: sizeMask = 4'h3;
      SZ_BYTE: sizeMask = 4'h0;
      SZ_HALF: sizeMask = 4'h1;
      default: sizeMask = 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
  import dma_stat_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             busy,
  input  logic             cfgBad,
  input  logic             startPulse,
  input  logic             rdBusErr,
  input  logic             wrBusErr,
  input  logic             beatDone,
  input  logic [CNT_W-1:0] bytesLeft,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [7:0]       regWrData,
  output statStrobe_t      strobe
);

  logic clearReq;
  logic startOk;
  logic anyErr;
  logic finalBeat;

  always_comb begin
    clearReq  = regWrEn && !regSel && regWrData[DoneBit];
    startOk   = startPulse && !busy && !clearReq;
    anyErr    = rdBusErr || wrBusErr;
    finalBeat = busy && beatDone && (bytesLeft == '0) && !anyErr && !clearReq;

    strobe           = '0;
    strobe.clrAll    = clearReq;
    strobe.setCfgErr = startOk && cfgBad;
    strobe.setBusy   = startOk && !cfgBad;
    strobe.setSrcErr = busy && rdBusErr && !clearReq;
    strobe.setDstErr = busy && wrBusErr && !clearReq;
    strobe.setDone   = finalBeat;
    strobe.clrBusy   = busy && (anyErr || finalBeat);
    strobe.wrVector  = regWrEn && regSel;
  end

endmodule

// File: rtl/dma_stat_dp.sv
module dma_stat_dp
  import dma_stat_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         CNT_W     = 24,
  parameter logic [7:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [1:0]        srcSize,
  input  logic [1:0]        dstSize,
  input  logic              grant,
  input  logic              intEnable,
  input  logic              regSel,
  input  logic [7:0]        regWrData,
  input  logic              iackStrobe,
  output logic              busy,
  output logic              cfgBad,
  output logic [7:0]        statusByte,
  output logic [7:0]        vectorQ,
  output logic [7:0]        regRdData,
  output logic [7:0]        busData,
  output logic              irq
);

  logic [3:0] srcMask;
  logic [3:0] dstMask;
  logic cfgErrQ, srcErrQ, dstErrQ, doneQ, busyQ;

  always_comb begin
    srcMask = sizeMask(srcSize);
    dstMask = sizeMask(dstSize);
    cfgBad  = ((byteCount & CNT_W'(srcMask))  != '0) ||
              ((byteCount & CNT_W'(dstMask))  != '0) ||
              ((srcAddr   & ADDR_W'(srcMask)) != '0) ||
              ((dstAddr   & ADDR_W'(dstMask)) != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgErrQ <= 1'b0;
      srcErrQ <= 1'b0;
      dstErrQ <= 1'b0;
      doneQ   <= 1'b0;
      busyQ   <= 1'b0;
    end else if (strobe.clrAll) begin
      cfgErrQ <= 1'b0;
      srcErrQ <= 1'b0;
      dstErrQ <= 1'b0;
      doneQ   <= 1'b0;
      busyQ   <= 1'b0;
    end else begin
      if (strobe.setCfgErr) cfgErrQ <= 1'b1;
      if (strobe.setSrcErr) srcErrQ <= 1'b1;
      if (strobe.setDstErr) dstErrQ <= 1'b1;
      if (strobe.setDone)   doneQ   <= 1'b1;
      if (strobe.setBusy)      busyQ <= 1'b1;
      else if (strobe.clrBusy) busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                vectorQ <= VEC_RESET;
    else if (strobe.wrVector) vectorQ <= regWrData;
  end

  always_comb begin
    busy                  = busyQ;
    statusByte            = '0;
    statusByte[CfgErrBit] = cfgErrQ;
    statusByte[SrcErrBit] = srcErrQ;
    statusByte[DstErrBit] = dstErrQ;
    statusByte[ReqBit]    = busyQ && !grant;
    statusByte[BusyBit]   = busyQ;
    statusByte[DoneBit]   = doneQ;
    regRdData = regSel ? vectorQ : statusByte;
    busData   = iackStrobe ? vectorQ : 8'h00;
    irq       = intEnable && (doneQ || cfgErrQ || srcErrQ || dstErrQ);
  end

endmodule

// File: rtl/dma_stat_tracker.sv
module dma_stat_tracker
  import dma_stat_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         CNT_W     = 24,
  parameter logic [7:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [1:0]        srcSize,
  input  logic [1:0]        dstSize,
  input  logic              grant,
  input  logic              rdBusErr,
  input  logic              wrBusErr,
  input  logic              beatDone,
  input  logic [CNT_W-1:0]  bytesLeft,
  input  logic              intEnable,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              iackStrobe,
  output logic [7:0]        busData,
  output logic              irq
);

  statStrobe_t strobe;
  logic        busy;
  logic        cfgBad;
  logic [7:0]  statusByte;
  logic [7:0]  vectorQ;

  dma_stat_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .busy       (busy),
    .cfgBad     (cfgBad),
    .startPulse (startPulse),
    .rdBusErr   (rdBusErr),
    .wrBusErr   (wrBusErr),
    .beatDone   (beatDone),
    .bytesLeft  (bytesLeft),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .strobe     (strobe)
  );

  dma_stat_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VEC_RESET(VEC_RESET)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .byteCount  (byteCount),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr),
    .srcSize    (srcSize),
    .dstSize    (dstSize),
    .grant      (grant),
    .intEnable  (intEnable),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .iackStrobe (iackStrobe),
    .busy       (busy),
    .cfgBad     (cfgBad),
    .statusByte (statusByte),
    .vectorQ    (vectorQ),
    .regRdData  (regRdData),
    .busData    (busData),
    .irq        (irq)
  );

endmodule

// File: rtl/dma_stat_tracker_chk.sv
module dma_stat_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       grant,
  input logic       rdBusErr,
  input logic       wrBusErr,
  input logic       intEnable,
  input logic       regWrEn,
  input logic       regSel,
  input logic [7:0] regWrData,
  input logic       iackStrobe,
  input logic [7:0] busData,
  input logic       irq,
  input logic       busy,
  input logic       cfgBad,
  input logic [7:0] statusByte,
  input logic [7:0] vectorQ
);

  logic wipe;
  assign wipe = regWrEn && !regSel && regWrData[0];

  p_cfg_blocks_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && cfgBad && !wipe) |=> (!busy && statusByte[6]));

  p_grant_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> !statusByte[2]);

  p_rd_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdBusErr && !wipe) |=> (!busy && statusByte[5]));

  p_wr_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrBusErr && !wipe) |=> (!busy && statusByte[4]));

  p_done_from_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> $past(busy));

  p_wipe_r7: assert property (@(posedge clk) disable iff (!rstN)
    wipe |=> (statusByte == 8'h00));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !irq);

  p_iack_r9: assert property (@(posedge clk) disable iff (!rstN)
    iackStrobe |-> (busData == vectorQ));

endmodule

bind dma_stat_tracker dma_stat_tracker_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .grant      (grant),
  .rdBusErr   (rdBusErr),
  .wrBusErr   (wrBusErr),
  .intEnable  (intEnable),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regWrData  (regWrData),
  .iackStrobe (iackStrobe),
  .busData    (busData),
  .irq        (irq),
  .busy       (busy),
  .cfgBad     (cfgBad),
  .statusByte (statusByte),
  .vectorQ    (vectorQ)
);

// File: tb/dma_stat_tracker_tb.sv
module dma_stat_tracker_tb;

  localparam int AW = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 0, grant = 0, rdBusErr = 0, wrBusErr = 0, beatDone = 0;
  logic [CW-1:0] byteCount = '0, bytesLeft = '0;
  logic [AW-1:0] srcAddr = '0, dstAddr = '0;
  logic [1:0]    srcSize = '0, dstSize = '0;
  logic          intEnable = 0, regWrEn = 0, regSel = 0, iackStrobe = 0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData, busData;
  logic          irq;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  dma_stat_tracker #(.ADDR_W(AW), .CNT_W(CW), .VEC_RESET(8'h0F)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteCount(byteCount),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcSize(srcSize), .dstSize(dstSize),
    .grant(grant), .rdBusErr(rdBusErr), .wrBusErr(wrBusErr), .beatDone(beatDone),
    .bytesLeft(bytesLeft), .intEnable(intEnable), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .iackStrobe(iackStrobe),
    .busData(busData), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int szBytes(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 16;
    endcase
  endfunction

  task automatic startXfer(input int cnt, input int sa, input int da, input int ss, input int ds);
    @(negedge clk);
    byteCount = CW'(cnt); srcAddr = AW'(sa); dstAddr = AW'(da);
    srcSize = 2'(ss); dstSize = 2'(ds); startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
  endtask

  task automatic pulseIn(input int which);
    @(negedge clk);
    case (which)
      0: rdBusErr = 1'b1;
      1: wrBusErr = 1'b1;
      2: begin rdBusErr = 1'b1; wrBusErr = 1'b1; end
      default: beatDone = 1'b1;
    endcase
    @(negedge clk);
    rdBusErr = 1'b0; wrBusErr = 1'b0; beatDone = 1'b0;
  endtask

  task automatic sweep(input bit dstSide);
    for (int ss = 0; ss < 4; ss++)
      for (int ds = 0; ds < 4; ds++)
        for (int cnt = 0; cnt < 32; cnt++)
          for (int off = 0; off < 16; off++) begin
            int sa = dstSide ? 32 : 32 + off;
            int da = dstSide ? 64 + off : 64;
            bit bad = (cnt % szBytes(ss) != 0) || (cnt % szBytes(ds) != 0) ||
                      (sa % szBytes(ss) != 0) || (da % szBytes(ds) != 0);
            startXfer(cnt, sa, da, ss, ds);
            check(bad ? "R2/R3 cfg error sweep" : "R3 clean start busy sweep",
                  regRdData, bad ? 8'h40 : 8'h06);
            writeReg(1'b0, 8'h01);
          end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status after reset", regRdData, 8'h00);
    regSel = 1'b1; #1;
    check("R1 vector after reset", regRdData, 8'h0F);
    regSel = 1'b0;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R9 bus idle", busData, 8'h00);

    // R2 R3 exhaustive setup sweeps
    sweep(1'b0);
    sweep(1'b1);

    // R4 request vs grant
    startXfer(16, 0, 0, 0, 0);
    check("R4 request while not granted", regRdData, 8'h06);
    @(negedge clk); grant = 1'b1; #1;
    check("R4 request dropped on grant", regRdData, 8'h02);
    @(negedge clk); grant = 1'b0; #1;
    check("R4 request back", regRdData, 8'h06);

    // R10 start while busy ignored
    startXfer(3, 1, 0, 0, 0);
    check("R10 start while busy ignored", regRdData, 8'h06);

    // R6 completion
    @(negedge clk); bytesLeft = CW'(4);
    pulseIn(3);
    check("R6 nonzero remaining no change", regRdData, 8'h06);
    bytesLeft = '0;
    intEnable = 1'b1;
    pulseIn(3);
    check("R6 done on final beat", regRdData, 8'h01);
    check("R8 irq on done", {7'd0, irq}, 8'h01);
    intEnable = 1'b0; #1;
    check("R8 irq masked", {7'd0, irq}, 8'h00);
    intEnable = 1'b1;

    // R7 write zero / write one
    writeReg(1'b0, 8'hFE);
    check("R7 write zero no effect", regRdData, 8'h01);
    writeReg(1'b0, 8'h01);
    check("R7 write one clears", regRdData, 8'h00);
    check("R8 irq drops after clear", {7'd0, irq}, 8'h00);

    // R5 bus errors
    startXfer(8, 0, 0, 0, 0);
    pulseIn(0);
    check("R5 read-phase error", regRdData, 8'h20);
    check("R8 irq on error", {7'd0, irq}, 8'h01);
    writeReg(1'b0, 8'h01);
    startXfer(8, 0, 0, 0, 0);
    pulseIn(1);
    check("R5 write-phase error", regRdData, 8'h10);
    writeReg(1'b0, 8'h01);
    startXfer(8, 0, 0, 0, 0);
    pulseIn(2);
    check("R5 both errors", regRdData, 8'h30);
    writeReg(1'b0, 8'h01);
    pulseIn(0);
    check("R5 error on idle ignored", regRdData, 8'h00);

    // R7 abort
    startXfer(8, 0, 0, 0, 0);
    writeReg(1'b0, 8'h01);
    check("R7 abort clears busy", regRdData, 8'h00);
    pulseIn(3);
    check("R7 no done after abort", regRdData, 8'h00);

    // R8 configuration error interrupt
    startXfer(5, 0, 0, 0, 0);
    check("R3 cfg error no busy", regRdData, 8'h40);
    check("R8 irq on cfg error", {7'd0, irq}, 8'h01);
    writeReg(1'b0, 8'h01);

    // R9 vector register and acknowledge
    writeReg(1'b1, 8'hA5);
    regSel = 1'b1; #1;
    check("R9 vector readback", regRdData, 8'hA5);
    regSel = 1'b0; #1;
    check("R9 status untouched by vector write", regRdData, 8'h00);
    @(negedge clk); iackStrobe = 1'b1; #1;
    check("R9 vector on bus", busData, 8'hA5);
    @(negedge clk); iackStrobe = 1'b0; #1;
    check("R9 bus released", busData, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule